// File: doc/BRIEF.md
# I2C Word-Write Slave Front-End

This block is the serial front end of a slave on a two-wire I2C bus. It runs on a system clock that is much faster than the bus clock, and it samples SCL and SDA through synchronizers. It takes part only in transfers that carry its own 7-bit address. On a write, the master sends a 16-bit word as two bytes, high byte first. Once the second byte has been acknowledged, the block presents the word on `wr_word` and pulses `wr_stb`. On a read, it returns the value on `rd_word` as two bytes.

The address is checked one bit at a time as the bits arrive. At the first bit that differs, the block drops out of the transfer and ignores the clock line until the next START. After a STOP it also stops watching SCL. SDA is driven only by pulling it low, through `sda_oe`. A write that ends before its second byte is acknowledged leaves nothing behind. Words may be streamed back to back within one transfer, or separated by repeated STARTs.

Top module: `i2c_word_slave`

## Requirements
- R1: Out of reset, `sda_oe`, `wr_stb` and `wr_word` are all 0.
- R2: The device address is `{ADDR_HI, addr_sel}`, with the address-select pin as the least significant bit. The eighth bit of the address byte selects the direction: 0 for write, 1 for read. A matching address is acknowledged by pulling SDA low during the ninth clock.
- R3: When an address bit differs from the expected one, the block gives no acknowledge. It then ignores every clock until the next START, so no later byte is acknowledged and no word is committed.
- R4: The all-zero general call address is not acknowledged.
- R5: In a write, each of the two data bytes is acknowledged. The first byte becomes `wr_word[15:8]` and the second becomes `wr_word[7:0]`, each sent MSB first. `wr_stb` pulses for one clock at the SCL falling edge that ends the second byte's acknowledge. In that same cycle the acknowledge is released.
- R6: A write cut short by a STOP or a repeated START before its second data byte is acknowledged produces no `wr_stb`.
- R7: Within one transfer, each further pair of bytes is committed as a new word. A repeated START followed by a fresh address also starts a new write.
- R8: After a STOP, bytes clocked without a new START, even ones that form a matching address, are not acknowledged and commit nothing.
- R9: In a read, the block sends `rd_word[15:8]` and then `rd_word[7:0]`, MSB first. It sends the second byte only if the master acknowledged the first. After a master NACK it leaves SDA released.
- R10: A STOP that arrives in the same SCL high period as the START before it is ignored, and the transfer continues.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level |
| addr_sel | input | 1 | Least significant bit of the device address |
| rd_word | input | 16 | Value returned by a read |
| sda_oe | output | 1 | When 1, pull SDA low |
| wr_word | output | 16 | Last committed write word |
| wr_stb | output | 1 | One-cycle pulse when a word is committed |

## Verification
The hardest situations to reach are the aborted writes and the disconnected states. In these, nothing visible happens at the ports, yet the block must still end in the right internal state. The stimulus cuts a write after a random number of bits of its second byte and ends it with either a STOP or a repeated START. It then shows that no strobe ever appears. To reach the disconnected states, it keeps clocking bytes after a mismatching address, and after a STOP with no new START. Some of those bytes would form a valid address and word, and none of them may be acknowledged. A STOP placed in the same high period as a START is driven directly. The write that follows it must still be acknowledged and committed.

// File: rtl/i2c_word_slave.sv
module i2c_word_slave #(
  parameter logic [5:0] ADDR_HI = 6'b101100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  input  logic        addr_sel,
  input  logic [15:0] rd_word,
  output logic        sda_oe,
  output logic [15:0] wr_word,
  output logic        wr_stb
);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WR, ST_RD} st_t;

  st_t        st;
  logic [2:0] scl_q, sda_q;
  logic [3:0] bit_cnt;
  logic [7:0] rx, hi;
  logic [15:0] tx;
  logic       byte2, rw, clk_seen, mack;

  logic       live, scl_hi, start_c, stop_c, rise, fall, bit_v;
  logic [6:0] addr7;

  assign live    = (st != ST_IDLE);
  assign scl_hi  = scl_q[1] & scl_q[2];
  assign start_c = scl_hi & sda_q[2] & ~sda_q[1];
  assign stop_c  = scl_hi & ~sda_q[2] & sda_q[1];
  assign rise    = live & scl_q[1] & ~scl_q[2];
  assign fall    = live & ~scl_q[1] & scl_q[2];
  assign bit_v   = sda_q[1];
  assign addr7   = {ADDR_HI, addr_sel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bit_cnt  <= '0;
      rx       <= '0;
      hi       <= '0;
      tx       <= '0;
      byte2    <= 1'b0;
      rw       <= 1'b0;
      clk_seen <= 1'b0;
      mack     <= 1'b0;
      sda_oe   <= 1'b0;
      wr_word  <= '0;
      wr_stb   <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (start_c) begin
        st       <= ST_ADDR;
        bit_cnt  <= '0;
        byte2    <= 1'b0;
        clk_seen <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_c && clk_seen) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (rise) begin
        if (bit_cnt < 4'd8) rx <= {rx[6:0], bit_v};
        if (bit_cnt == 4'd8) mack <= ~bit_v;
        if (bit_cnt < 4'd9) bit_cnt <= bit_cnt + 4'd1;
        if (st == ST_ADDR && bit_cnt < 4'd7 && bit_v != addr7[3'd6 - bit_cnt[2:0]])
          st <= ST_IDLE;
        if (st == ST_ADDR && bit_cnt == 4'd7) rw <= bit_v;
      end else if (fall) begin
        clk_seen <= 1'b1;
        if (bit_cnt == 4'd8) begin
          if (st != ST_RD) sda_oe <= 1'b1;
          else begin
            sda_oe <= 1'b0;
            tx     <= tx << 1;
          end
        end else if (bit_cnt == 4'd9) begin
          bit_cnt <= '0;
          sda_oe  <= 1'b0;
          case (st)
            ST_ADDR: begin
              byte2 <= 1'b0;
              if (rw) begin
                st     <= ST_RD;
                tx     <= rd_word;
                sda_oe <= ~rd_word[15];
              end else begin
                st <= ST_WR;
              end
            end
            ST_WR: begin
              if (!byte2) begin
                hi    <= rx;
                byte2 <= 1'b1;
              end else begin
                wr_word <= {hi, rx};
                wr_stb  <= 1'b1;
                byte2   <= 1'b0;
              end
            end
            ST_RD: begin
              if (mack && !byte2) begin
                byte2  <= 1'b1;
                sda_oe <= ~tx[15];
              end else begin
                st <= ST_IDLE;
              end
            end
            default: st <= ST_IDLE;
          endcase
        end else if (bit_cnt != 4'd0 && st == ST_RD) begin
          tx     <= tx << 1;
          sda_oe <= ~tx[14];
        end
      end
    end
  end

endmodule

// File: rtl/i2c_word_slave_chk.sv
module i2c_word_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       sda_oe,
  input logic       wr_stb,
  input logic [1:0] st
);

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_in); // R11

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R5

  AST_COMMIT_ENDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(sda_oe) && !sda_oe)); // R5

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |-> !sda_oe); // R3

  AST_NO_COMMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (st != 2'd0)); // R8

endmodule

bind i2c_word_slave i2c_word_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe), .wr_stb(wr_stb), .st(st)
);

// File: tb/i2c_word_slave_bench.sv
module i2c_word_slave_bench;
  localparam int CLK_NS = 10;
  localparam int Q = 8;
  localparam logic [5:0] AHI = 6'b101100;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic [15:0] rd_word = '0;
  logic sda_bus, sda_oe, wr_stb;
  logic [15:0] wr_word;
  int vecs = 0, miss = 0, stb_cnt = 0, oe_bad = 0;
  logic [15:0] got_word = '0;
  logic oe_prev = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;

  always #(CLK_NS/2) clk = ~clk;

  i2c_word_slave #(.ADDR_HI(AHI)) u_i2c_word_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .addr_sel(addr_sel),
    .rd_word(rd_word), .sda_oe(sda_oe), .wr_word(wr_word), .wr_stb(wr_stb)
  );

  always @(negedge clk) begin
    if (wr_stb) begin
      stb_cnt = stb_cnt + 1;
      got_word = wr_word;
    end
    if (rst_n && sda_oe !== oe_prev && scl_m) oe_bad = oe_bad + 1;
    oe_prev = sda_oe;
  end

  function automatic logic [7:0] addr_byte(input logic sel, input logic rwb);
    return {AHI, sel, rwb};
  endfunction

  function automatic logic [6:0] wrong_addr(input logic [6:0] seed_v, input logic sel);
    logic [6:0] a;
    a = seed_v;
    if (a == {AHI, sel} || a == 7'd0) a = {~AHI, sel} ^ 7'h40;
    return a;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq();
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_m = b; hq(); scl_m = 1'b1; hq(); seen = sda_bus; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      v[i] = s;
    end
    clk_bit(~give_ack, s);
  endtask

  task automatic wr_words(input int n);
    logic a;
    logic [15:0] w;
    int base;
    base = stb_cnt;
    put_byte(addr_byte(addr_sel, 1'b0), a);
    check("R2 write address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      w = 16'($urandom);
      put_byte(w[15:8], a);
      check("R5 first data byte ack", a, 1);
      put_byte(w[7:0], a);
      check("R5 second data byte ack", a, 1);
      hq();
      check("R7 words committed in transfer", stb_cnt - base, k + 1);
      check("R5 committed word", got_word, w);
    end
  endtask

  task automatic rd_check(input logic ack1);
    logic a;
    logic [7:0] b;
    rd_word = 16'($urandom);
    bus_start();
    put_byte(addr_byte(addr_sel, 1'b1), a);
    check("R2 read address ack", a, 1);
    get_byte(ack1, b);
    check("R9 read high byte", b, rd_word[15:8]);
    get_byte(1'b0, b);
    if (ack1) check("R9 read low byte", b, rd_word[7:0]);
    else check("R9 SDA released after NACK", b, 8'hFF);
    bus_stop();
  endtask

  task automatic mismatch_case();
    logic a;
    int base;
    logic [6:0] wa;
    base = stb_cnt;
    wa = wrong_addr(7'($urandom), addr_sel);
    bus_start();
    put_byte({wa, 1'b0}, a);
    check("R3 mismatching address not acked", a, 0);
    put_byte(addr_byte(addr_sel, 1'b0), a);
    check("R3 byte after mismatch not acked", a, 0);
    put_byte(8'($urandom), a);
    check("R3 second byte after mismatch not acked", a, 0);
    put_byte(8'($urandom), a);
    hq();
    check("R3 nothing committed after mismatch", stb_cnt - base, 0);
    bus_stop();
  endtask

  task automatic abort_case(input logic use_restart);
    logic a, s;
    int base, k;
    base = stb_cnt;
    bus_start();
    put_byte(addr_byte(addr_sel, 1'b0), a);
    check("R2 address ack before abort", a, 1);
    put_byte(8'($urandom), a);
    check("R5 first byte ack before abort", a, 1);
    k = $urandom_range(0, 7);
    for (int i = 0; i < k; i++) clk_bit(1'($urandom), s);
    if (use_restart) bus_start();
    bus_stop();
    hq();
    check("R6 aborted write commits nothing", stb_cnt - base, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miss++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic a;
    int base;
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    check("R1 sda_oe in reset", sda_oe, 0);
    check("R1 wr_stb in reset", wr_stb, 0);
    check("R1 wr_word in reset", wr_word, 0);
    rst_n = 1'b1;
    hq();

    addr_sel = 1'b0; bus_start(); wr_words(1); bus_stop();
    addr_sel = 1'b1; bus_start(); wr_words(2); bus_stop();

    base = stb_cnt;
    sda_m = 1'b0; hq(); sda_m = 1'b1; hq(); scl_m = 1'b0; hq();
    put_byte(addr_byte(addr_sel, 1'b0), a);
    check("R10 early STOP ignored, address acked", a, 1);
    put_byte(8'h3C, a);
    put_byte(8'h5A, a);
    hq();
    check("R10 write after early STOP committed", stb_cnt - base, 1);
    check("R10 word after early STOP", got_word, 16'h3C5A);
    bus_stop();

    bus_start(); wr_words(1); bus_start(); wr_words(1); bus_stop();

    rd_check(1'b1);
    rd_check(1'b0);

    bus_start();
    put_byte(8'h00, a);
    check("R4 general call not acked", a, 0);
    bus_stop();

    base = stb_cnt;
    scl_m = 1'b0; hq();
    put_byte(addr_byte(addr_sel, 1'b0), a);
    check("R8 address after STOP without START not acked", a, 0);
    put_byte(8'h12, a);
    check("R8 data after STOP not acked", a, 0);
    put_byte(8'h34, a);
    hq();
    check("R8 nothing committed after STOP", stb_cnt - base, 0);
    bus_stop();

    mismatch_case();
    abort_case(1'b0);
    abort_case(1'b1);

    for (int it = 0; it < 50; it++) begin
      addr_sel = 1'($urandom);
      case ($urandom_range(0, 4))
        0: begin bus_start(); wr_words($urandom_range(1, 3)); bus_stop(); end
        1: rd_check(1'($urandom));
        2: mismatch_case();
        3: abort_case(1'($urandom));
        default: begin bus_start(); wr_words(1); bus_start(); wr_words(1); bus_stop(); end
      endcase
    end

    check("R11 sda_oe never changed with SCL high", oe_bad, 0);
    finish_run();
  end
endmodule